// File: doc/BRIEF.md
# Auxiliary-Memory Copy Engine

This block moves data between main memory and a separate auxiliary memory, in either direction. Software programs a 32-bit main address, a 32-bit auxiliary address and a 32-bit count word through a 16-bit register port, one half at a time. The count word holds a 31-bit byte length and a direction flag in its top bit. Writing the low half of the count launches the copy. The engine then moves 64-bit beats, eight bytes each, until the length reaches zero. At that point it drops `busy` and pulses `done` for one cycle, which goes to the interrupt controller.

Addresses and lengths move in 32-byte units because the low halves lose their bottom five bits when written. At launch both addresses are folded into a 64 MB window. An auxiliary address at or above the installed size takes one of two paths, depending on direction. A fetch from that space returns zeros to main memory. A store into that space touches neither memory, and the registers jump straight to their final values.

Each memory side is a request/grant stream port. A request holds its address, write flag and write data steady until the grant arrives. Read data is taken in the grant cycle. The memory exerts back-pressure simply by withholding the grant.

Top module: `aux_dma_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, and every address and count half reads 0. The status register (select 6) reads 0x0001.
- R2: Writing select 1 (main low), 3 (aux low) or 5 (count low) stores the data with bits [4:0] cleared. Selects 0, 2 and 4 (the high halves) store all 16 bits. Readback returns the stored value at the same select.
- R3: Select 6 stores bits [15:1] as written, and bit 0 always reads 1.
- R4: A write to select 5 while idle starts a copy, and `busy` reads 1 from the next cycle. In that same write cycle both 32-bit addresses are masked to their low 26 bits.
- R5: With count bit 31 (select 4 bit 15) at 0, each 8-byte beat is read from main memory and written to auxiliary memory. Each beat adds 8 to both addresses and subtracts 8 from the length.
- R6: With count bit 31 at 1, each beat is read from auxiliary memory and written to main memory, with the same address and length steps as R5.
- R7: With direction 1 and an auxiliary start address at or above `AUX_BYTES`, auxiliary memory is never accessed and main memory receives an all-zero beat for every 8 bytes of length.
- R8: With direction 0 and an auxiliary start address at or above `AUX_BYTES`, neither memory is accessed. Both addresses advance by the full length, the length becomes 0 and the copy finishes.
- R9: `busy` falls in the same cycle that `done` is 1, and `done` lasts exactly one cycle. A zero length finishes one cycle after launch with no memory access.
- R10: A request stays asserted with a stable address, write flag and write data until it is granted. At most one port requests at a time, and neither port requests while idle.
- R11: While `busy` is 1, writes to selects 0 to 5 are ignored, so a launch cannot restart or alter a running copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..6) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Readback of the selected register |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mm_req | output | 1 | Main memory request (valid) |
| mm_we | output | 1 | Main memory request is a write |
| mm_addr | output | ADDR_W | Main memory byte address |
| mm_wdata | output | DATA_W | Main memory write data |
| mm_gnt | input | 1 | Main memory grant (ready) |
| mm_rdata | input | DATA_W | Main memory read data, valid with grant |
| ax_req | output | 1 | Auxiliary memory request (valid) |
| ax_we | output | 1 | Auxiliary memory request is a write |
| ax_addr | output | ADDR_W | Auxiliary memory byte address |
| ax_wdata | output | DATA_W | Auxiliary memory write data |
| ax_gnt | input | 1 | Auxiliary memory grant (ready) |
| ax_rdata | input | DATA_W | Auxiliary memory read data, valid with grant |

## Verification
A software launch can land in the very cycle the engine is finishing, while `busy` is still 1 and `done` is about to rise. The bench provokes this with a zero-length launch. It then holds a second count-low write, of 0x0020, across the completion edge. The outcome is judged at the ports: exactly one `done` pulse, `busy` low afterwards, count low reading 0 and no memory request. Register writes landing during live beats are covered separately: the final addresses, length and beat count must match the original program.

// File: rtl/aux_dma_pkg.sv
package aux_dma_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MAIN_HI = 3'd0,
    SEL_MAIN_LO = 3'd1,
    SEL_AUX_HI  = 3'd2,
    SEL_AUX_LO  = 3'd3,
    SEL_CNT_HI  = 3'd4,
    SEL_CNT_LO  = 3'd5,
    SEL_STATUS  = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_READ,
    ST_WRITE
  } eng_state_e;

  typedef struct packed {
    logic [31:0] main_addr;
    logic [31:0] aux_addr;
    logic [31:0] count;
  } xfer_regs_t;
endpackage

// File: rtl/aux_dma_regs.sv
module aux_dma_regs
  import aux_dma_pkg::*;
#(
  parameter int ADDR_W     = 26,
  parameter int ALIGN_BITS = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [15:0]      reg_wdata,
  output logic [15:0]      reg_rdata,
  input  logic             busy_i,
  input  logic             upd_en_i,
  input  xfer_regs_t       upd_vals_i,
  output xfer_regs_t       regs_o,
  output logic             start_o
);
  localparam logic [31:0] MIRROR_MASK = (32'd1 << ADDR_W) - 32'd1;
  localparam logic [15:0] LOW_MASK    = ~((16'd1 << ALIGN_BITS) - 16'd1);

  xfer_regs_t  r_q;
  logic [15:0] status_q;
  logic        wr_ok;
  logic [15:0] low_val;

  assign wr_ok   = reg_we && !busy_i;
  assign low_val = reg_wdata & LOW_MASK;
  assign start_o = wr_ok && (reg_sel == SEL_CNT_LO);
  assign regs_o  = r_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_q <= '0;
    end else if (upd_en_i) begin
      r_q <= upd_vals_i;
    end else if (wr_ok) begin
      case (reg_sel_e'(reg_sel))
        SEL_MAIN_HI: r_q.main_addr[31:16] <= reg_wdata;
        SEL_MAIN_LO: r_q.main_addr[15:0]  <= low_val;
        SEL_AUX_HI:  r_q.aux_addr[31:16]  <= reg_wdata;
        SEL_AUX_LO:  r_q.aux_addr[15:0]   <= low_val;
        SEL_CNT_HI:  r_q.count[31:16]     <= reg_wdata;
        SEL_CNT_LO: begin
          r_q.count[15:0] <= low_val;
          r_q.main_addr   <= r_q.main_addr & MIRROR_MASK;
          r_q.aux_addr    <= r_q.aux_addr & MIRROR_MASK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else if (reg_we && (reg_sel == SEL_STATUS)) status_q <= reg_wdata;
  end

  always_comb begin
    case (reg_sel_e'(reg_sel))
      SEL_MAIN_HI: reg_rdata = r_q.main_addr[31:16];
      SEL_MAIN_LO: reg_rdata = r_q.main_addr[15:0];
      SEL_AUX_HI:  reg_rdata = r_q.aux_addr[31:16];
      SEL_AUX_LO:  reg_rdata = r_q.aux_addr[15:0];
      SEL_CNT_HI:  reg_rdata = r_q.count[31:16];
      SEL_CNT_LO:  reg_rdata = r_q.count[15:0];
      SEL_STATUS:  reg_rdata = {status_q[15:1], 1'b1};
      default:     reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/aux_dma_core.sv
module aux_dma_core
  import aux_dma_pkg::*;
#(
  parameter int          ADDR_W     = 26,
  parameter int          DATA_W     = 64,
  parameter int          BEAT_BYTES = 8,
  parameter int unsigned AUX_BYTES  = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  xfer_regs_t        regs_i,
  output logic              upd_en_o,
  output xfer_regs_t        upd_vals_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              mm_req,
  output logic              mm_we,
  output logic [ADDR_W-1:0] mm_addr,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic              mm_gnt,
  input  logic [DATA_W-1:0] mm_rdata,
  output logic              ax_req,
  output logic              ax_we,
  output logic [ADDR_W-1:0] ax_addr,
  output logic [DATA_W-1:0] ax_wdata,
  input  logic              ax_gnt,
  input  logic [DATA_W-1:0] ax_rdata
);
  localparam logic [31:0] MIRROR_MASK = (32'd1 << ADDR_W) - 32'd1;
  localparam logic [31:0] STEP32      = 32'(BEAT_BYTES);
  localparam logic [30:0] STEP31      = 31'(BEAT_BYTES);

  eng_state_e        state_q, state_d;
  logic              oor_q, oor_d, oor_now;
  logic              done_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              dir;
  logic [30:0]       len;
  logic              src_gnt, dst_gnt;
  logic [DATA_W-1:0] src_rdata;

  generate
    if (longint'(AUX_BYTES) >= (longint'(1) << ADDR_W)) begin : g_aux_full
      assign oor_now = 1'b0;
    end else begin : g_aux_part
      assign oor_now = ((regs_i.aux_addr & MIRROR_MASK) >= AUX_BYTES);
    end
  endgenerate

  assign dir       = regs_i.count[31];
  assign len       = regs_i.count[30:0];
  assign src_gnt   = dir ? ax_gnt : mm_gnt;
  assign dst_gnt   = dir ? mm_gnt : ax_gnt;
  assign src_rdata = dir ? ax_rdata : mm_rdata;

  always_comb begin
    state_d    = state_q;
    oor_d      = oor_q;
    data_d     = data_q;
    done_d     = 1'b0;
    upd_en_o   = 1'b0;
    upd_vals_o = regs_i;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          oor_d   = oor_now;
        end
      end
      ST_RUN: begin
        if (len == '0) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (oor_q && !dir) begin
          upd_en_o             = 1'b1;
          upd_vals_o.main_addr = regs_i.main_addr + {1'b0, len};
          upd_vals_o.aux_addr  = regs_i.aux_addr + {1'b0, len};
          upd_vals_o.count     = {dir, 31'd0};
        end else if (oor_q) begin
          data_d  = '0;
          state_d = ST_WRITE;
        end else begin
          state_d = ST_READ;
        end
      end
      ST_READ: begin
        if (src_gnt) begin
          data_d  = src_rdata;
          state_d = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (dst_gnt) begin
          upd_en_o             = 1'b1;
          upd_vals_o.main_addr = regs_i.main_addr + STEP32;
          upd_vals_o.aux_addr  = regs_i.aux_addr + STEP32;
          upd_vals_o.count     = {dir, len - STEP31};
          state_d              = ST_RUN;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      oor_q   <= 1'b0;
      data_q  <= '0;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      oor_q   <= oor_d;
      data_q  <= data_d;
      done_o  <= done_d;
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign mm_req   = ((state_q == ST_READ) && !dir) || ((state_q == ST_WRITE) && dir);
  assign ax_req   = ((state_q == ST_READ) && dir) || ((state_q == ST_WRITE) && !dir);
  assign mm_we    = (state_q == ST_WRITE);
  assign ax_we    = (state_q == ST_WRITE);
  assign mm_addr  = regs_i.main_addr[ADDR_W-1:0];
  assign ax_addr  = regs_i.aux_addr[ADDR_W-1:0];
  assign mm_wdata = data_q;
  assign ax_wdata = data_q;
endmodule

// File: rtl/aux_dma_engine.sv
module aux_dma_engine
  import aux_dma_pkg::*;
#(
  parameter int          ADDR_W     = 26,
  parameter int          DATA_W     = 64,
  parameter int          BEAT_BYTES = 8,
  parameter int unsigned AUX_BYTES  = 32'h0100_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              busy,
  output logic              done,
  output logic              mm_req,
  output logic              mm_we,
  output logic [ADDR_W-1:0] mm_addr,
  output logic [DATA_W-1:0] mm_wdata,
  input  logic              mm_gnt,
  input  logic [DATA_W-1:0] mm_rdata,
  output logic              ax_req,
  output logic              ax_we,
  output logic [ADDR_W-1:0] ax_addr,
  output logic [DATA_W-1:0] ax_wdata,
  input  logic              ax_gnt,
  input  logic [DATA_W-1:0] ax_rdata
);
  xfer_regs_t regs, upd_vals;
  logic       upd_en, start;

  aux_dma_regs #(.ADDR_W(ADDR_W), .ALIGN_BITS(5)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy_i     (busy),
    .upd_en_i   (upd_en),
    .upd_vals_i (upd_vals),
    .regs_o     (regs),
    .start_o    (start)
  );

  aux_dma_core #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEAT_BYTES(BEAT_BYTES), .AUX_BYTES(AUX_BYTES)
  ) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .regs_i     (regs),
    .upd_en_o   (upd_en),
    .upd_vals_o (upd_vals),
    .busy_o     (busy),
    .done_o     (done),
    .mm_req     (mm_req),
    .mm_we      (mm_we),
    .mm_addr    (mm_addr),
    .mm_wdata   (mm_wdata),
    .mm_gnt     (mm_gnt),
    .mm_rdata   (mm_rdata),
    .ax_req     (ax_req),
    .ax_we      (ax_we),
    .ax_addr    (ax_addr),
    .ax_wdata   (ax_wdata),
    .ax_gnt     (ax_gnt),
    .ax_rdata   (ax_rdata)
  );
endmodule

// File: rtl/aux_dma_checker.sv
module aux_dma_checker #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              reg_we,
  input logic [2:0]        reg_sel,
  input logic              mm_req,
  input logic              mm_we,
  input logic [ADDR_W-1:0] mm_addr,
  input logic [DATA_W-1:0] mm_wdata,
  input logic              mm_gnt,
  input logic              ax_req,
  input logic              ax_we,
  input logic [ADDR_W-1:0] ax_addr,
  input logic [DATA_W-1:0] ax_wdata,
  input logic              ax_gnt
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_WITH_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(busy)); // R9
  AST_FALL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
  AST_START_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(reg_we) && ($past(reg_sel) == 3'd5))); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mm_req && !ax_req)); // R10
  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    !(mm_req && ax_req)); // R10
  AST_MM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req && !mm_gnt) |=> (mm_req && $stable(mm_addr) && $stable(mm_we) && $stable(mm_wdata))); // R10
  AST_AX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ax_req && !ax_gnt) |=> (ax_req && $stable(ax_addr) && $stable(ax_we) && $stable(ax_wdata))); // R10
  AST_BEAT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_req || ax_req) |-> ((mm_addr[2:0] == 3'd0) && (ax_addr[2:0] == 3'd0))); // R5
endmodule

bind aux_dma_engine aux_dma_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_aux_dma_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .reg_we   (reg_we),
  .reg_sel  (reg_sel),
  .mm_req   (mm_req),
  .mm_we    (mm_we),
  .mm_addr  (mm_addr),
  .mm_wdata (mm_wdata),
  .mm_gnt   (mm_gnt),
  .ax_req   (ax_req),
  .ax_we    (ax_we),
  .ax_addr  (ax_addr),
  .ax_wdata (ax_wdata),
  .ax_gnt   (ax_gnt)
);

// File: tb/test_aux_dma_engine.sv
`timescale 1ns/1ps
module test_aux_dma_engine;
  localparam int AW = 26;
  localparam int DW = 64;
  localparam logic [31:0] AUX_SIZE = 32'h0100_0000;

  typedef struct packed {
    logic        dir;
    logic [15:0] mh, ml, ah, al, cl;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'h0000, 16'h0040, 16'h0000, 16'h0200, 16'h0040},
    '{1'b1, 16'h0000, 16'h0300, 16'h0000, 16'h0080, 16'h0020},
    '{1'b0, 16'h0C00, 16'h0100, 16'h0400, 16'h0400, 16'h0020},
    '{1'b1, 16'h0000, 16'h0600, 16'h0100, 16'h0000, 16'h0040},
    '{1'b0, 16'h0000, 16'h0000, 16'h0180, 16'h0000, 16'h0060},
    '{1'b0, 16'h0000, 16'h004F, 16'h0000, 16'h07C0, 16'h003F}
  };

  logic clk = 0;
  logic rst_n = 0;
  logic reg_we = 0;
  logic [2:0] reg_sel = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic busy, done;
  logic mm_req, mm_we, ax_req, ax_we;
  logic [AW-1:0] mm_addr, ax_addr;
  logic [DW-1:0] mm_wdata, ax_wdata;
  logic mm_gnt = 0, ax_gnt = 0;
  logic [DW-1:0] mm_rdata = 0, ax_rdata = 0;

  logic [DW-1:0] mmem [256];
  logic [DW-1:0] amem [256];
  logic mem_init = 1;
  logic [3:0] stall_ctr = 0;
  int mm_acc = 0, ax_acc = 0, done_cnt = 0;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  aux_dma_engine i_aux_dma_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .done(done),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_gnt(mm_gnt), .mm_rdata(mm_rdata),
    .ax_req(ax_req), .ax_we(ax_we), .ax_addr(ax_addr), .ax_wdata(ax_wdata),
    .ax_gnt(ax_gnt), .ax_rdata(ax_rdata)
  );

  function automatic logic [63:0] main_pat(int i);
    return {32'hA11A_0000 | 32'(i), 32'h0F0F_0000 ^ 32'(i)};
  endfunction
  function automatic logic [63:0] aux_pat(int i);
    return {32'h5EE5_0000 | 32'(i), 32'hC3C3_0000 | 32'(i)};
  endfunction

  // memory models with request/grant handshake and periodic stalls
  always @(posedge clk) begin
    stall_ctr <= stall_ctr + 4'd1;
    if (mem_init) begin
      for (int i = 0; i < 256; i++) begin
        mmem[i] <= main_pat(i);
        amem[i] <= aux_pat(i);
      end
      mm_acc <= 0; ax_acc <= 0; mm_gnt <= 0; ax_gnt <= 0;
    end else begin
      mm_gnt   <= mm_req && !mm_gnt && (stall_ctr[1:0] != 2'd0);
      ax_gnt   <= ax_req && !ax_gnt && (stall_ctr[1:0] != 2'd1);
      mm_rdata <= mmem[mm_addr[10:3]];
      ax_rdata <= amem[ax_addr[10:3]];
      if (mm_req && mm_gnt) begin
        mm_acc <= mm_acc + 1;
        if (mm_we) mmem[mm_addr[10:3]] <= mm_wdata;
      end
      if (ax_req && ax_gnt) begin
        ax_acc <= ax_acc + 1;
        if (ax_we) amem[ax_addr[10:3]] <= ax_wdata;
      end
    end
  end

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  task automatic wr(logic [2:0] sel, logic [15:0] val);
    @(negedge clk);
    reg_we = 1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] sel, output logic [15:0] val);
    @(negedge clk);
    reg_sel = sel;
    #1 val = reg_rdata;
  endtask

  task automatic rd32(logic [2:0] sel_hi, output logic [31:0] val);
    logic [15:0] h, l;
    rd(sel_hi, h);
    rd(sel_hi + 3'd1, l);
    val = {h, l};
  endtask

  task automatic init_mem();
    @(negedge clk); mem_init = 1;
    @(negedge clk); mem_init = 0;
  endtask

  task automatic wait_done(string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, req, {63'd0, done}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [31:0] v32;
    repeat (3) @(negedge clk);
    rst_n = 1;
    mem_init = 0;

    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v);
      chk(v == 16'h0, "R1 reg reset", v, 0);
    end
    rd(3'd6, v);
    chk(v == 16'h0001, "R1 status reset", v, 16'h0001);

    // R2 alignment of low halves, high halves whole
    wr(3'd1, 16'h1234); rd(3'd1, v);
    chk(v == 16'h1220, "R2 main low aligned", v, 16'h1220);
    wr(3'd0, 16'hBEEF); rd(3'd0, v);
    chk(v == 16'hBEEF, "R2 main high whole", v, 16'hBEEF);
    wr(3'd3, 16'hFFFF); rd(3'd3, v);
    chk(v == 16'hFFE0, "R2 aux low aligned", v, 16'hFFE0);

    // R3 status bit 0
    wr(3'd6, 16'h0000); rd(3'd6, v);
    chk(v == 16'h0001, "R3 status lsb", v, 16'h0001);
    wr(3'd6, 16'hA5A4); rd(3'd6, v);
    chk(v == 16'hA5A5, "R3 status upper", v, 16'hA5A5);

    // vector table
    for (int k = 0; k < 6; k++) begin
      vec_t t;
      logic [31:0] m, a, len, em, ea;
      bit oor;
      int beats, mi, ai;
      string rq;
      t = VECS[k];
      m = {t.mh, t.ml & 16'hFFE0} & 32'h03FF_FFFF;
      a = {t.ah, t.al & 16'hFFE0} & 32'h03FF_FFFF;
      len = {16'h0, t.cl & 16'hFFE0};
      oor = (a >= AUX_SIZE);
      beats = int'(len >> 3);
      em = m + len; ea = a + len;
      rq = oor ? (t.dir ? "R7" : "R8") : (t.dir ? "R6" : "R5");
      init_mem();
      wr(3'd0, t.mh); wr(3'd1, t.ml); wr(3'd2, t.ah); wr(3'd3, t.al);
      wr(3'd4, {t.dir, 15'd0}); wr(3'd5, t.cl);
      chk(busy == 1'b1, "R4 busy after start", {63'd0, busy}, 64'd1);
      wait_done(rq);
      @(negedge clk);
      rd32(3'd0, v32); chk(v32 == em, {rq, " main final (R4 mirror)"}, v32, em);
      rd32(3'd2, v32); chk(v32 == ea, {rq, " aux final"}, v32, ea);
      rd32(3'd4, v32); chk(v32 == {t.dir, 31'd0}, {rq, " count final"}, v32, {t.dir, 31'd0});
      mi = int'(m[10:3]); ai = int'(a[10:3]);
      if (oor && !t.dir) begin
        chk(mm_acc == 0 && ax_acc == 0, "R8 no access", 64'(mm_acc + ax_acc), 0);
      end else if (oor) begin
        chk(ax_acc == 0, "R7 aux untouched", 64'(ax_acc), 0);
        chk(mm_acc == beats, "R7 main beats", 64'(mm_acc), 64'(beats));
        for (int b = 0; b < beats; b++)
          chk(mmem[(mi + b) % 256] == 64'd0, "R7 zero beat", mmem[(mi + b) % 256], 0);
      end else begin
        chk(mm_acc == beats && ax_acc == beats, "R10 beat handshakes",
            64'(mm_acc), 64'(beats));
        for (int b = 0; b < beats; b++) begin
          if (t.dir)
            chk(mmem[(mi + b) % 256] == aux_pat((ai + b) % 256), rq,
                mmem[(mi + b) % 256], aux_pat((ai + b) % 256));
          else
            chk(amem[(ai + b) % 256] == main_pat((mi + b) % 256), rq,
                amem[(ai + b) % 256], main_pat((mi + b) % 256));
        end
      end
    end

    // R9 zero length plus launch colliding with completion
    init_mem();
    wr(3'd0, 16'h0); wr(3'd1, 16'h0); wr(3'd2, 16'h0); wr(3'd3, 16'h0); wr(3'd4, 16'h0);
    begin
      int d0;
      d0 = done_cnt;
      @(negedge clk); reg_we = 1; reg_sel = 3'd5; reg_wdata = 16'h0000;
      @(negedge clk);
      chk(busy == 1 && done == 0, "R9 zero len busy", {busy, done}, 2'b10);
      reg_wdata = 16'h0020;
      @(negedge clk); reg_we = 0;
      chk(busy == 0 && done == 1, "R9 zero len finish", {busy, done}, 2'b01);
      @(negedge clk);
      chk(busy == 0 && done == 0, "R9 done one cycle", {busy, done}, 2'b00);
      rd(3'd5, v);
      chk(v == 16'h0, "R11 launch at finish ignored", v, 0);
      chk(done_cnt - d0 == 1, "R9 single done", 64'(done_cnt - d0), 1);
      chk(mm_acc == 0 && ax_acc == 0, "R9 no access", 64'(mm_acc + ax_acc), 0);
    end

    // R11 writes during a running copy are ignored
    init_mem();
    wr(3'd0, 16'h0); wr(3'd1, 16'h0040); wr(3'd2, 16'h0); wr(3'd3, 16'h0200);
    wr(3'd4, 16'h0000); wr(3'd5, 16'h0040);
    wr(3'd1, 16'h0700); wr(3'd5, 16'h0100); wr(3'd4, 16'h8000);
    wait_done("R11");
    @(negedge clk);
    rd32(3'd0, v32); chk(v32 == 32'h80, "R11 main unchanged by busy write", v32, 32'h80);
    rd32(3'd2, v32); chk(v32 == 32'h240, "R11 aux final", v32, 32'h240);
    rd32(3'd4, v32); chk(v32 == 32'h0, "R11 count/dir unchanged", v32, 0);
    chk(mm_acc == 8, "R11 beat count", 64'(mm_acc), 8);

    finished = 1;
    summary();
    $finish;
  end
endmodule